// File: doc/BRIEF.md
# Queued conversion scan sequencer

This block walks a queue of conversion command words stored in a small command RAM. For each word it raises a request to an abstract converter, with a channel and a sample-time select. It waits for the converter's done strobe and then stores the returned result in a result RAM, at the index of the word that produced it. A queue pass ends at the first word whose channel field holds the end-of-queue code, or after the word at the last index.

A two-bit mode input selects one of four continuous-scan variants. They differ only in what starts a pass:

- **Self-started:** the block starts each pass itself.
- **Edge-started:** a rising edge on an external trigger pin starts a pass.
- **Gate-held:** a pass runs while an external gate is high.
- **Timer-started:** an internal interval timer starts each pass.

The block reports:

- a queue status: idle, active or paused;
- a one-cycle pass-complete pulse;
- a sticky trigger-overrun flag, cleared by a strobe.

Top module: `scan_sequencer`

## Requirements
- R1: After a synchronous reset, status reads idle (code 0), no conversion is requested, and both the pass-complete pulse and the overrun flag are low.
- R2: A command word is 10 bits: bit 9 is the pause bit, bits 8:7 are the sample-time select and bits 6:0 are the channel. Words are issued one request at a time, in index order starting at index 0. Each result is written to the result RAM at the issuing word's index. A request stays high until done is seen.
- R3: A word whose channel is 63 ends the pass and issues no request. Normally the next request appears 2 cycles after the done strobe. When the pass wraps through the end-of-queue word, the first request of the next pass appears 3 cycles after the last done.
- R4: If no end-of-queue word is present, finishing the word at the last index (DEPTH-1) ends the pass.
- R5: In self-started mode (code 0), the first request appears 2 cycles after the enable goes high. Passes restart at word 0 after each end of queue. Pause bits do not stop execution, and status never reads paused.
- R6: In edge-started mode (code 1), nothing is issued until a rising edge of the trigger pin, which passes through a two-flop synchronizer. After a pass, status is idle, and the next edge restarts the queue at word 0.
- R7: In edge-started and timer-started modes, after the result of a word with the pause bit set is written, status reads paused (code 2). The next trigger resumes execution at the following word and does not count as an overrun.
- R8: A trigger that arrives while a pass is fetching or converting sets the sticky overrun flag, in edge-started and timer-started modes only. The flag is never set in self-started or gate-held modes. The flag stays set until the clear strobe.
- R9: In gate-held mode (code 2), passes repeat back to back while the synchronized gate is high, and pause bits are ignored. When the gate falls, the conversion in flight completes and the block returns to idle.
- R10: In timer-started mode (code 3), a pass starts every TIMER_PERIOD cycles.
- R11: The pass-complete output is high for exactly one cycle at each end of pass.
- R12: While the enable is low, the block stays idle and issues no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_en | input | 1 | Queue enable; low forces idle |
| mode | input | 2 | 0 self-started, 1 edge-started, 2 gate-held, 3 timer-started |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| ext_trig | input | 1 | External trigger pin (rising edge) |
| gate_in | input | 1 | External gate pin |
| cmd_we | input | 1 | Command RAM write enable |
| cmd_waddr | input | AW | Command RAM write index |
| cmd_wdata | input | 10 | Command word |
| res_raddr | input | AW | Result RAM read index |
| res_rdata | output | RES_W | Result RAM read data (combinational) |
| conv_req | output | 1 | Conversion request |
| conv_ch | output | 7 | Channel of the current request |
| conv_st | output | 2 | Sample-time select of the current request |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | RES_W | Converter result, valid with done |
| status | output | 2 | 0 idle, 1 active, 2 paused |
| pass_done | output | 1 | One-cycle end-of-pass pulse |
| trig_ovr | output | 1 | Sticky trigger-overrun flag |

## Verification
The bench first runs one short queue containing a pause word and an end-of-queue word under each of the four start modes. This separates self-started continuation from pause-and-resume and from gate-held stopping. Overrun is provoked by triggers that land during a pass, which tells a resume trigger apart from an overrun. A shorter queue under the timer proves that passes start at exactly the period. A longer queue under the timer drives that mode into overrun. A full 64-word queue with no end-of-queue code checks the last-index wrap and its normal 2-cycle spacing against the 3-cycle end-of-queue wrap.

// File: rtl/scanq_pkg.sv
package scanq_pkg;

    localparam int CH_W  = 7;
    localparam int ST_W  = 2;
    localparam int CMD_W = 1 + ST_W + CH_W;

    localparam logic [CH_W-1:0] EOQ_CH = CH_W'(63);

    typedef enum logic [1:0] {
        MODE_SW   = 2'd0,
        MODE_EXT  = 2'd1,
        MODE_GATE = 2'd2,
        MODE_TMR  = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        QS_IDLE   = 2'd0,
        QS_ACTIVE = 2'd1,
        QS_PAUSED = 2'd2
    } q_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_CONV,
        S_HOLD
    } seq_state_e;

    typedef struct packed {
        logic            pause;
        logic [ST_W-1:0] st;
        logic [CH_W-1:0] ch;
    } cmd_word_t;

    function automatic logic captures_overrun(scan_mode_e m);
        return (m == MODE_EXT) || (m == MODE_TMR);
    endfunction

endpackage

// File: rtl/scanq_ram.sv
module scanq_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/scanq_trigger.sv
module scanq_trigger
    import scanq_pkg::*;
#(
    parameter int TIMER_PERIOD = 64,
    localparam int TW = $clog2(TIMER_PERIOD)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  scan_mode_e mode,
    input  logic       ext_trig,
    input  logic       gate_in,
    output logic       start_evt,
    output logic       gate_on
);
    logic [2:0]    ext_sy;
    logic [1:0]    gate_sy;
    logic [TW-1:0] tcnt;
    logic          edge_p;
    logic          tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_sy  <= '0;
            gate_sy <= '0;
            tcnt    <= '0;
        end else begin
            ext_sy  <= {ext_sy[1:0], ext_trig};
            gate_sy <= {gate_sy[0], gate_in};
            if (en && mode == MODE_TMR) tcnt <= tick ? '0 : tcnt + 1'b1;
            else                        tcnt <= '0;
        end
    end

    assign edge_p  = ext_sy[1] & ~ext_sy[2];
    assign tick    = (tcnt == TW'(TIMER_PERIOD - 1));
    assign gate_on = gate_sy[1];

    always_comb begin
        unique case (mode)
            MODE_SW:   start_evt = 1'b1;
            MODE_EXT:  start_evt = edge_p;
            MODE_GATE: start_evt = gate_on;
            default:   start_evt = tick;
        endcase
    end

    // R6: a synchronized edge yields a single-cycle event
    assert_edge_single_R6: assert property (@(posedge clk) disable iff (rst)
        edge_p |=> !edge_p);

    // R10: timer ticks never come back to back
    assert_tick_gap_R10: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/scanq_fsm.sv
module scanq_fsm
    import scanq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int RES_W = 10,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  scan_mode_e       mode,
    input  logic             start_evt,
    input  logic             gate_on,
    input  logic             ovr_clr,
    input  cmd_word_t        cmd,
    output logic [AW-1:0]    cmd_raddr,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_ch,
    output logic [ST_W-1:0]  conv_st,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             res_we,
    output logic [AW-1:0]    res_waddr,
    output logic [RES_W-1:0] res_wdata,
    output q_status_e        status,
    output logic             ovr,
    output logic             pass_done
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    seq_state_e    state;
    logic [AW-1:0] idx;
    cmd_word_t     cur;
    logic          restart;
    logic          cap_mode;

    assign restart  = (mode == MODE_SW) || (mode == MODE_GATE && gate_on);
    assign cap_mode = captures_overrun(mode);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state     <= S_IDLE;
            idx       <= '0;
            cur       <= '0;
            pass_done <= 1'b0;
        end else begin
            pass_done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start_evt) begin
                        state <= S_FETCH;
                        idx   <= '0;
                    end
                end
                S_FETCH: begin
                    if (cmd.ch == EOQ_CH) begin
                        pass_done <= 1'b1;
                        idx       <= '0;
                        state     <= restart ? S_FETCH : S_IDLE;
                    end else begin
                        cur   <= cmd;
                        state <= S_CONV;
                    end
                end
                S_CONV: begin
                    if (conv_done) begin
                        if (idx == LAST) begin
                            pass_done <= 1'b1;
                            idx       <= '0;
                            state     <= restart ? S_FETCH : S_IDLE;
                        end else if (cur.pause && cap_mode) begin
                            state <= S_HOLD;
                        end else if (mode == MODE_GATE && !gate_on) begin
                            idx   <= '0;
                            state <= S_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_FETCH;
                        end
                    end
                end
                S_HOLD: begin
                    if (start_evt) begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovr <= 1'b0;
        else if (en && cap_mode && start_evt && (state == S_FETCH || state == S_CONV))
            ovr <= 1'b1;
        else if (ovr_clr)
            ovr <= 1'b0;
    end

    assign cmd_raddr = idx;
    assign conv_req  = (state == S_CONV);
    assign conv_ch   = cur.ch;
    assign conv_st   = cur.st;
    assign res_we    = (state == S_CONV) && conv_done;
    assign res_waddr = idx;
    assign res_wdata = conv_result;

    always_comb begin
        unique case (state)
            S_IDLE:  status = QS_IDLE;
            S_HOLD:  status = QS_PAUSED;
            default: status = QS_ACTIVE;
        endcase
    end

    // R2: a request is only withdrawn after done or on disable
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_req) |-> ($past(conv_done) || !$past(en)));

    // R7: paused status only appears in modes that pause
    assert_pause_mode_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(status == QS_PAUSED) |-> captures_overrun(mode));

    // R8: overrun is sticky until the clear strobe
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);

    // R8: overrun only rises in capturing modes
    assert_ovr_mode_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> captures_overrun(scan_mode_e'($past(mode))));
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scanq_pkg::*;
#(
    parameter int DEPTH        = 64,
    parameter int RES_W        = 10,
    parameter int TIMER_PERIOD = 64,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_en,
    input  logic [1:0]       mode,
    input  logic             ovr_clr,
    input  logic             ext_trig,
    input  logic             gate_in,
    input  logic             cmd_we,
    input  logic [AW-1:0]    cmd_waddr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic [AW-1:0]    res_raddr,
    output logic [RES_W-1:0] res_rdata,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_ch,
    output logic [ST_W-1:0]  conv_st,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic [1:0]       status,
    output logic             pass_done,
    output logic             trig_ovr
);
    scan_mode_e       mode_e;
    logic             start_evt;
    logic             gate_on;
    logic [AW-1:0]    cmd_raddr;
    logic [CMD_W-1:0] cmd_rdata;
    logic             res_we;
    logic [AW-1:0]    res_waddr;
    logic [RES_W-1:0] res_wdata;
    q_status_e        status_e;

    assign mode_e = scan_mode_e'(mode);
    assign status = status_e;

    scanq_ram #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_ram (
        .clk(clk), .we(cmd_we), .waddr(cmd_waddr), .wdata(cmd_wdata),
        .raddr(cmd_raddr), .rdata(cmd_rdata)
    );

    scanq_ram #(.W(RES_W), .DEPTH(DEPTH)) u_res_ram (
        .clk(clk), .we(res_we), .waddr(res_waddr), .wdata(res_wdata),
        .raddr(res_raddr), .rdata(res_rdata)
    );

    scanq_trigger #(.TIMER_PERIOD(TIMER_PERIOD)) u_trig (
        .clk(clk), .rst(rst), .en(q_en), .mode(mode_e),
        .ext_trig(ext_trig), .gate_in(gate_in),
        .start_evt(start_evt), .gate_on(gate_on)
    );

    scanq_fsm #(.DEPTH(DEPTH), .RES_W(RES_W)) u_fsm (
        .clk(clk), .rst(rst), .en(q_en), .mode(mode_e),
        .start_evt(start_evt), .gate_on(gate_on), .ovr_clr(ovr_clr),
        .cmd(cmd_word_t'(cmd_rdata)), .cmd_raddr(cmd_raddr),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_st(conv_st),
        .conv_done(conv_done), .conv_result(conv_result),
        .res_we(res_we), .res_waddr(res_waddr), .res_wdata(res_wdata),
        .status(status_e), .ovr(trig_ovr), .pass_done(pass_done)
    );

    // R12: no request while disabled
    assert_no_req_disabled_R12: assert property (@(posedge clk) disable iff (rst)
        !q_en |=> !conv_req);
endmodule

// File: tb/scan_sequencer_bench.sv
module scan_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int RES_W      = 10;
    localparam int TPER       = 40;
    localparam int LAT        = 3;
    localparam int AW         = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             q_en = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic             ovr_clr = 1'b0;
    logic             ext_trig = 1'b0;
    logic             gate_in = 1'b0;
    logic             cmd_we = 1'b0;
    logic [AW-1:0]    cmd_waddr = '0;
    logic [9:0]       cmd_wdata = '0;
    logic [AW-1:0]    res_raddr = '0;
    logic [RES_W-1:0] res_rdata;
    logic             conv_req;
    logic [6:0]       conv_ch;
    logic [1:0]       conv_st;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_result = '0;
    logic [1:0]       status;
    logic             pass_done;
    logic             trig_ovr;

    scan_sequencer #(.DEPTH(DEPTH), .RES_W(RES_W), .TIMER_PERIOD(TPER)) u_scan_sequencer (
        .clk(clk), .rst(rst), .q_en(q_en), .mode(mode), .ovr_clr(ovr_clr),
        .ext_trig(ext_trig), .gate_in(gate_in), .cmd_we(cmd_we),
        .cmd_waddr(cmd_waddr), .cmd_wdata(cmd_wdata), .res_raddr(res_raddr),
        .res_rdata(res_rdata), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_st(conv_st), .conv_done(conv_done), .conv_result(conv_result),
        .status(status), .pass_done(pass_done), .trig_ovr(trig_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [RES_W-1:0] model_res(input int ch, input int st);
        return RES_W'(ch * 3 + st);
    endfunction

    // converter model
    int       cv_cnt = 0;
    int       cv_ch = 0;
    int       cv_st = 0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (rst) cv_cnt <= 0;
        else if (cv_cnt != 0) begin
            cv_cnt <= cv_cnt - 1;
            if (cv_cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= model_res(cv_ch, cv_st);
            end
        end else if (conv_req && !conv_done) begin
            cv_cnt <= LAT;
            cv_ch  <= int'(conv_ch);
            cv_st  <= int'(conv_st);
        end
    end

    // monitor
    int cyc = 0, n = 0, last_done = 0, pd_rises = 0, pd_cycles = 0;
    int log_ch[512], log_st[512], log_t[512], log_gap[512];
    bit req_q = 0, pd_q = 0, seen_pause = 0;
    always @(negedge clk) begin
        cyc++;
        if (conv_done) last_done = cyc;
        if (conv_req && !req_q) begin
            if (n < 512) begin
                log_ch[n]  = int'(conv_ch);
                log_st[n]  = int'(conv_st);
                log_t[n]   = cyc;
                log_gap[n] = cyc - last_done;
            end
            n++;
        end
        req_q = conv_req;
        if (status == 2'd2) seen_pause = 1;
        if (pass_done) begin
            pd_cycles++;
            if (!pd_q) pd_rises++;
        end
        pd_q = pass_done;
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk_eq(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_cmd(input int a, input bit p, input int st, input int ch);
        cmd_waddr = AW'(a);
        cmd_wdata = {p, 2'(st), 7'(ch)};
        cmd_we    = 1'b1;
        step();
        cmd_we    = 1'b0;
    endtask

    task automatic pulse_trig();
        ext_trig = 1'b1;
        repeat (3) step();
        ext_trig = 1'b0;
    endtask

    task automatic load_short();
        for (int i = 0; i < 5; i++) wr_cmd(i, i == 2, sq_st[i], sq_ch[i]);
        wr_cmd(5, 1'b0, 0, 63);
    endtask

    int sq_ch[5] = '{5, 12, 33, 7, 20};
    int sq_st[5] = '{0, 1, 2, 3, 1};

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base, pd0, t_en, nsave;
        repeat (4) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk_eq("R1 status", int'(status), 0);
        chk_eq("R1 req", int'(conv_req), 0);
        chk_eq("R1 ovr", int'(trig_ovr), 0);
        chk_eq("R1 pass_done", int'(pass_done), 0);

        // ---- self-started mode: R2 R3 R5 R11
        load_short();
        mode = 2'd0;
        base = n; pd0 = pd_rises; seen_pause = 0;
        q_en = 1'b1; t_en = cyc;
        for (int k = 0; k < 400 && pd_rises < pd0 + 3; k++) step();
        q_en = 1'b0;
        chk_eq("R5 start latency", log_t[base] - t_en, 2);
        for (int k = 0; k < 15; k++) begin
            chk_eq("R2 channel order", log_ch[base + k], sq_ch[k % 5]);
            chk_eq("R2 sample time", log_st[base + k], sq_st[k % 5]);
            if (k > 0) chk_eq("R3 request spacing", log_gap[base + k], (k % 5 == 0) ? 3 : 2);
        end
        chk_eq("R5 never paused", int'(seen_pause), 0);
        chk_eq("R8 no overrun in self-started", int'(trig_ovr), 0);
        for (int i = 0; i < 5; i++) begin
            res_raddr = AW'(i);
            #1;
            chk_eq("R2 result at index", int'(res_rdata), int'(model_res(sq_ch[i], sq_st[i])));
        end
        // R12 disable
        repeat (3) step();
        chk_eq("R12 idle when disabled", int'(status), 0);
        chk_eq("R12 no request when disabled", int'(conv_req), 0);
        nsave = n;
        repeat (20) step();
        chk_eq("R12 no new requests", n, nsave);

        // ---- edge-started mode: R6 R7 R8
        mode = 2'd1;
        q_en = 1'b1;
        base = n;
        repeat (20) step();
        chk_eq("R6 waits for edge", n - base, 0);
        pulse_trig();
        for (int k = 0; k < 200 && status != 2'd2; k++) step();
        chk_eq("R7 paused status", int'(status), 2);
        chk_eq("R7 words before pause", n - base, 3);
        pulse_trig();
        for (int k = 0; k < 200 && !(status == 2'd0 && n - base >= 5); k++) step();
        chk_eq("R7 resume at next word", log_ch[base + 3], sq_ch[3]);
        chk_eq("R6 idle after pass", int'(status), 0);
        chk_eq("R7 resume is not overrun", int'(trig_ovr), 0);
        pulse_trig();
        for (int k = 0; k < 200 && n - base < 6; k++) step();
        chk_eq("R6 restart at word 0", log_ch[base + 5], sq_ch[0]);
        pulse_trig();
        repeat (4) step();
        chk_eq("R8 overrun while active", int'(trig_ovr), 1);
        for (int k = 0; k < 200 && status != 2'd2; k++) step();
        repeat (10) step();
        chk_eq("R8 overrun sticky", int'(trig_ovr), 1);
        pulse_trig();
        for (int k = 0; k < 200 && !(status == 2'd0 && n - base >= 10); k++) step();
        ovr_clr = 1'b1;
        step();
        ovr_clr = 1'b0;
        step();
        chk_eq("R8 clear strobe", int'(trig_ovr), 0);
        q_en = 1'b0;
        repeat (3) step();

        // ---- gate-held mode: R9
        mode = 2'd2;
        q_en = 1'b1;
        base = n; seen_pause = 0;
        repeat (10) step();
        chk_eq("R9 gate low issues nothing", n - base, 0);
        gate_in = 1'b1;
        pd0 = pd_rises;
        for (int k = 0; k < 400 && pd_rises < pd0 + 2; k++) step();
        for (int k = 0; k < 10; k++)
            chk_eq("R9 gated order", log_ch[base + k], sq_ch[k % 5]);
        chk_eq("R9 pause ignored", int'(seen_pause), 0);
        repeat (8) step();
        gate_in = 1'b0;
        for (int k = 0; k < 50 && status != 2'd0; k++) step();
        chk_eq("R9 idle after gate falls", int'(status), 0);
        nsave = n;
        repeat (20) step();
        chk_eq("R9 stays stopped", n, nsave);
        chk_eq("R8 no overrun in gated", int'(trig_ovr), 0);
        q_en = 1'b0;
        step();

        // ---- timer-started mode: R10 R8
        mode = 2'd3;
        wr_cmd(0, 1'b0, 1, 9);
        wr_cmd(1, 1'b0, 2, 10);
        wr_cmd(2, 1'b0, 0, 63);
        base = n; pd0 = pd_rises;
        q_en = 1'b1;
        for (int k = 0; k < 400 && pd_rises < pd0 + 3; k++) step();
        chk_eq("R10 pass period a", log_t[base + 2] - log_t[base], TPER);
        chk_eq("R10 pass period b", log_t[base + 4] - log_t[base + 2], TPER);
        chk_eq("R10 no overrun short queue", int'(trig_ovr), 0);
        q_en = 1'b0;
        for (int i = 0; i < 10; i++) wr_cmd(i, 1'b0, 0, i + 1);
        wr_cmd(10, 1'b0, 0, 63);
        base = n;
        q_en = 1'b1;
        for (int k = 0; k < 600 && n - base < 12; k++) step();
        chk_eq("R8 timer overrun", int'(trig_ovr), 1);
        q_en = 1'b0;
        ovr_clr = 1'b1;
        step();
        ovr_clr = 1'b0;
        repeat (3) step();

        // ---- last index wrap: R4
        mode = 2'd0;
        for (int i = 0; i < DEPTH; i++) wr_cmd(i, 1'b0, i % 4, (i % 50) + 1);
        base = n;
        q_en = 1'b1;
        for (int k = 0; k < 1000 && n - base < 66; k++) step();
        q_en = 1'b0;
        chk_eq("R4 last word issued", log_ch[base + 63], (63 % 50) + 1);
        chk_eq("R4 wrap to word 0", log_ch[base + 64], 1);
        chk_eq("R4 wrap spacing", log_gap[base + 64], 2);
        res_raddr = AW'(DEPTH - 1);
        #1;
        chk_eq("R4 result at last index", int'(res_rdata), int'(model_res(14, 3)));
        chk_eq("R11 single-cycle pulses", pd_cycles, pd_rises);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule